// File: doc/BRIEF.md
# Accumulator ALU with Decimal Correction

This block is the arithmetic and logic core of a small 8-bit accumulator machine. It holds the accumulator, the carry flag, the half-carry flag and a compare result. Each clock cycle in which `opValid` is high, it applies the operation on `opCode` to the accumulator and the 8-bit `operand`. The operand comes from memory or from an immediate. The result and the updated flags are visible on the outputs after that clock edge.

Subtraction exists only in a with-carry form, in which the carry means "no borrow". A decimal-correct operation uses the carry and half-carry left by the most recent add-with-carry or subtract-with-carry to turn a binary result into a valid two-digit BCD value. For this, the block remembers internally which of those two operations ran last.

The compare operations drive `condOut`, which the sequencer uses to decide whether to skip the next instruction. The compares leave the accumulator untouched.

Top module: `acc_alu_bcd`

## Requirements
- R1: Operation codes on `opCode`: 0 no-op, 1 ADD, 2 ADC, 3 SUBC, 4 AND, 5 OR, 6 XOR, 7 compare-equal, 8 compare-greater, 9 clear, 10 increment, 11 decrement, 12 rotate right through carry, 13 nibble swap, 14 set carry, 15 clear carry, 16 decimal correct. Codes 17 to 31, and any code while `opValid` is low, change no output and no internal state.
- R2: While `rstN` is low, and after reset, the accumulator, carry, half-carry and condition are 0, and decimal correct is in after-add mode.
- R3: ADD loads A with (A + operand) mod 256 and leaves carry and half-carry unchanged.
- R4: ADC loads A with (A + operand + C) mod 256. C becomes the carry out of bit 7, and HC becomes the carry out of bit 3 (low nibbles plus C).
- R5: SUBC loads A with (A + ~operand + C) mod 256. C becomes the carry out of bit 7, so 1 means no borrow. HC becomes the carry out of bit 3 of the same sum.
- R6: AND, OR and XOR load A with the bitwise result and leave C and HC unchanged.
- R7: Compare-equal sets `condOut` to (A == operand), and compare-greater sets it to (A > operand) as unsigned values. `condOut` changes only on a compare and holds otherwise. A compare changes neither A nor the flags.
- R8: Clear loads A with 0. Increment and decrement change A by one, wrapping modulo 256. None of the three changes C or HC.
- R9: Rotate right through carry loads A with {C, A[7:1]} and C with the old A[0]. HC is unchanged.
- R10: Swap loads A with {A[3:0], A[7:4]} and leaves the flags unchanged.
- R11: Set carry makes C = 1 and clear carry makes C = 0. Both leave A and HC unchanged.
- R12: Decimal correct after an ADC (or after reset) adds 0x06 when HC = 1 or A[3:0] > 9. It adds 0x60 when C = 1 or A > 0x99. The sum wraps modulo 256.
- R13: Decimal correct after a SUBC subtracts 0x06 when HC = 0 and subtracts 0x60 when C = 0. The mode follows the most recent ADC or SUBC. Decimal correct leaves C and HC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Execute the operation on opCode this cycle |
| opCode | input | 5 | Operation select, encoding in R1 |
| operand | input | 8 | Memory or immediate operand |
| accOut | output | 8 | Accumulator |
| carryOut | output | 1 | Carry flag |
| halfCarryOut | output | 1 | Half-carry flag |
| condOut | output | 1 | Result of the latest compare |

## Verification
The hardest case to reach from the ports is decimal correct in the right mode with the right flag history. It needs an accumulator holding a BCD-looking value, a preceding ADC or SUBC that left a particular carry and half-carry, and no other ADC or SUBC in between. Directed sequences build this case on purpose: clear, OR in a value, set or clear the carry, ADC or SUBC, then decimal correct, with the expected values written out. A long random stream of all codes, including the unused ones, then mixes the flag-producing operations with decimal correct in arbitrary orders. A bench reference model is compared with the outputs after every operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int ACC_W = 8;
  localparam int NIB_W = ACC_W / 2;
  localparam int OP_W  = 5;

  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [ACC_W-1:0] BCD_MAX   = {DIGIT_MAX, DIGIT_MAX};
  localparam logic [ACC_W-1:0] LOW_FIX   = {{NIB_W{1'b0}}, NIB_W'(6)};
  localparam logic [ACC_W-1:0] HIGH_FIX  = {NIB_W'(6), {NIB_W{1'b0}}};

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADC  = 5'd2,
    OP_SUBC = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_CEQ  = 5'd7,
    OP_CGT  = 5'd8,
    OP_CLR  = 5'd9,
    OP_INC  = 5'd10,
    OP_DEC  = 5'd11,
    OP_RRC  = 5'd12,
    OP_SWAP = 5'd13,
    OP_SETC = 5'd14,
    OP_CLRC = 5'd15,
    OP_DCOR = 5'd16
  } aluOp_e;

  typedef struct packed {
    logic   accWe;
    logic   carryWe;
    logic   halfWe;
    logic   condWe;
    logic   modeWe;
    logic   modeSub;
    aluOp_e sel;
  } aluStrobe_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strobe
);

  always_comb begin
    strobe = '0;
    if (opValid) begin
      case (opCode)
        OP_ADD: begin
          strobe.sel   = OP_ADD;
          strobe.accWe = 1'b1;
        end
        OP_ADC: begin
          strobe.sel     = OP_ADC;
          strobe.accWe   = 1'b1;
          strobe.carryWe = 1'b1;
          strobe.halfWe  = 1'b1;
          strobe.modeWe  = 1'b1;
          strobe.modeSub = 1'b0;
        end
        OP_SUBC: begin
          strobe.sel     = OP_SUBC;
          strobe.accWe   = 1'b1;
          strobe.carryWe = 1'b1;
          strobe.halfWe  = 1'b1;
          strobe.modeWe  = 1'b1;
          strobe.modeSub = 1'b1;
        end
        OP_AND: begin
          strobe.sel   = OP_AND;
          strobe.accWe = 1'b1;
        end
        OP_OR: begin
          strobe.sel   = OP_OR;
          strobe.accWe = 1'b1;
        end
        OP_XOR: begin
          strobe.sel   = OP_XOR;
          strobe.accWe = 1'b1;
        end
        OP_CEQ: begin
          strobe.sel    = OP_CEQ;
          strobe.condWe = 1'b1;
        end
        OP_CGT: begin
          strobe.sel    = OP_CGT;
          strobe.condWe = 1'b1;
        end
        OP_CLR: begin
          strobe.sel   = OP_CLR;
          strobe.accWe = 1'b1;
        end
        OP_INC: begin
          strobe.sel   = OP_INC;
          strobe.accWe = 1'b1;
        end
        OP_DEC: begin
          strobe.sel   = OP_DEC;
          strobe.accWe = 1'b1;
        end
        OP_RRC: begin
          strobe.sel     = OP_RRC;
          strobe.accWe   = 1'b1;
          strobe.carryWe = 1'b1;
        end
        OP_SWAP: begin
          strobe.sel   = OP_SWAP;
          strobe.accWe = 1'b1;
        end
        OP_SETC: begin
          strobe.sel     = OP_SETC;
          strobe.carryWe = 1'b1;
        end
        OP_CLRC: begin
          strobe.sel     = OP_CLRC;
          strobe.carryWe = 1'b1;
        end
        OP_DCOR: begin
          strobe.sel   = OP_DCOR;
          strobe.accWe = 1'b1;
        end
        default: strobe = '0;
      endcase
    end
  end

  // R7: a compare never also targets the accumulator or the flags
  always_comb begin
    if (strobe.condWe) begin
      assert_cmp_isolated_R7: assert (!strobe.accWe && !strobe.carryWe && !strobe.halfWe);
    end
  end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobe_t       strobe,
  input  logic [ACC_W-1:0] operand,
  output logic [ACC_W-1:0] accQ,
  output logic             carryQ,
  output logic             halfQ,
  output logic             condQ
);

  logic             modeSubQ;
  logic [ACC_W:0]   sumPlain;
  logic [ACC_W:0]   sumCarry;
  logic [ACC_W:0]   sumBorrow;
  logic [NIB_W:0]   nibCarry;
  logic [NIB_W:0]   nibBorrow;
  logic [ACC_W-1:0] addFix;
  logic [ACC_W-1:0] subFix;
  logic [ACC_W-1:0] decResult;
  logic [ACC_W-1:0] accNext;
  logic             carryNext;
  logic             halfNext;
  logic             condNext;

  always_comb begin
    sumPlain  = {1'b0, accQ} + {1'b0, operand};
    sumCarry  = {1'b0, accQ} + {1'b0, operand} + {{ACC_W{1'b0}}, carryQ};
    sumBorrow = {1'b0, accQ} + {1'b0, ~operand} + {{ACC_W{1'b0}}, carryQ};
    nibCarry  = {1'b0, accQ[NIB_W-1:0]} + {1'b0, operand[NIB_W-1:0]}
              + {{NIB_W{1'b0}}, carryQ};
    nibBorrow = {1'b0, accQ[NIB_W-1:0]} + {1'b0, ~operand[NIB_W-1:0]}
              + {{NIB_W{1'b0}}, carryQ};
  end

  always_comb begin
    addFix = '0;
    if (halfQ || (accQ[NIB_W-1:0] > DIGIT_MAX)) addFix = addFix | LOW_FIX;
    if (carryQ || (accQ > BCD_MAX))             addFix = addFix | HIGH_FIX;
    subFix = '0;
    if (!halfQ)  subFix = subFix | LOW_FIX;
    if (!carryQ) subFix = subFix | HIGH_FIX;
    decResult = modeSubQ ? (accQ - subFix) : (accQ + addFix);
  end

  always_comb begin
    accNext   = accQ;
    carryNext = carryQ;
    halfNext  = halfQ;
    condNext  = condQ;
    case (strobe.sel)
      OP_ADD:  accNext = sumPlain[ACC_W-1:0];
      OP_ADC: begin
        accNext   = sumCarry[ACC_W-1:0];
        carryNext = sumCarry[ACC_W];
        halfNext  = nibCarry[NIB_W];
      end
      OP_SUBC: begin
        accNext   = sumBorrow[ACC_W-1:0];
        carryNext = sumBorrow[ACC_W];
        halfNext  = nibBorrow[NIB_W];
      end
      OP_AND:  accNext = accQ & operand;
      OP_OR:   accNext = accQ | operand;
      OP_XOR:  accNext = accQ ^ operand;
      OP_CEQ:  condNext = (accQ == operand);
      OP_CGT:  condNext = (accQ > operand);
      OP_CLR:  accNext = '0;
      OP_INC:  accNext = accQ + 1'b1;
      OP_DEC:  accNext = accQ - 1'b1;
      OP_RRC: begin
        accNext   = {carryQ, accQ[ACC_W-1:1]};
        carryNext = accQ[0];
      end
      OP_SWAP: accNext = {accQ[NIB_W-1:0], accQ[ACC_W-1:NIB_W]};
      OP_SETC: carryNext = 1'b1;
      OP_CLRC: carryNext = 1'b0;
      OP_DCOR: accNext = decResult;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ     <= '0;
      carryQ   <= 1'b0;
      halfQ    <= 1'b0;
      condQ    <= 1'b0;
      modeSubQ <= 1'b0;
    end else begin
      if (strobe.accWe)   accQ     <= accNext;
      if (strobe.carryWe) carryQ   <= carryNext;
      if (strobe.halfWe)  halfQ    <= halfNext;
      if (strobe.condWe)  condQ    <= condNext;
      if (strobe.modeWe)  modeSubQ <= strobe.modeSub;
    end
  end

  // R10: nibbles exchange places
  assert_swap_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sel == OP_SWAP |=>
      accQ == {$past(accQ[NIB_W-1:0]), $past(accQ[ACC_W-1:NIB_W])});

  // R9: carry enters at the top, bit 0 leaves into carry
  assert_rrc_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sel == OP_RRC |=>
      (accQ == {$past(carryQ), $past(accQ[ACC_W-1:1])}) && (carryQ == $past(accQ[0]))
      && $stable(halfQ));

  // R6: logical operations keep both flags
  assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == OP_AND || strobe.sel == OP_OR || strobe.sel == OP_XOR) |=>
      $stable(carryQ) && $stable(halfQ));

  // R7: compares keep the accumulator
  assert_cmp_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == OP_CEQ || strobe.sel == OP_CGT) |=> $stable(accQ));

  // R8: clear leaves zero
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sel == OP_CLR |=> accQ == '0);

  // R11: set carry leaves a one in carry and keeps HC
  assert_setc_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sel == OP_SETC |=> carryQ && $stable(halfQ));

  // R13: decimal correct keeps both flags
  assert_dcor_flags_R13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sel == OP_DCOR |=> $stable(carryQ) && $stable(halfQ));

endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opCode,
  input  logic [ACC_W-1:0] operand,
  output logic [ACC_W-1:0] accOut,
  output logic             carryOut,
  output logic             halfCarryOut,
  output logic             condOut
);

  aluStrobe_t strobe;

  acc_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  acc_alu_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .operand (operand),
    .accQ    (accOut),
    .carryQ  (carryOut),
    .halfQ   (halfCarryOut),
    .condQ   (condOut)
  );

endmodule

// File: tb/acc_alu_bcd_tb.sv
module acc_alu_bcd_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [4:0] opCode;
  logic [7:0] operand;
  logic [7:0] accOut;
  logic       carryOut;
  logic       halfCarryOut;
  logic       condOut;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] mA;
  logic       mC;
  logic       mH;
  logic       mCond;
  logic       mSub;

  acc_alu_bcd u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .opValid      (opValid),
    .opCode       (opCode),
    .operand      (operand),
    .accOut       (accOut),
    .carryOut     (carryOut),
    .halfCarryOut (halfCarryOut),
    .condOut      (condOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic string reqOf(input logic [4:0] code);
    case (code)
      5'd1:               return "R3";
      5'd2:               return "R4";
      5'd3:               return "R5";
      5'd4, 5'd5, 5'd6:   return "R6";
      5'd7, 5'd8:         return "R7";
      5'd9, 5'd10, 5'd11: return "R8";
      5'd12:              return "R9";
      5'd13:              return "R10";
      5'd14, 5'd15:       return "R11";
      5'd16:              return mSub ? "R13" : "R12";
      default:            return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep(input logic [4:0] code, input logic [7:0] v);
    logic [8:0] s;
    logic [4:0] n;
    logic [7:0] fix;
    case (code)
      5'd1: mA = mA + v;
      5'd2: begin
        s = {1'b0, mA} + {1'b0, v} + 9'(mC);
        n = {1'b0, mA[3:0]} + {1'b0, v[3:0]} + 5'(mC);
        mA = s[7:0]; mC = s[8]; mH = n[4]; mSub = 1'b0;
      end
      5'd3: begin
        s = {1'b0, mA} + {1'b0, ~v} + 9'(mC);
        n = {1'b0, mA[3:0]} + {1'b0, ~v[3:0]} + 5'(mC);
        mA = s[7:0]; mC = s[8]; mH = n[4]; mSub = 1'b1;
      end
      5'd4:  mA = mA & v;
      5'd5:  mA = mA | v;
      5'd6:  mA = mA ^ v;
      5'd7:  mCond = (mA == v);
      5'd8:  mCond = (mA > v);
      5'd9:  mA = 8'h00;
      5'd10: mA = mA + 8'h01;
      5'd11: mA = mA - 8'h01;
      5'd12: {mA, mC} = {mC, mA};
      5'd13: mA = {mA[3:0], mA[7:4]};
      5'd14: mC = 1'b1;
      5'd15: mC = 1'b0;
      5'd16: begin
        fix = 8'h00;
        if (mSub) begin
          if (!mH) fix = fix + 8'h06;
          if (!mC) fix = fix + 8'h60;
          mA = mA - fix;
        end else begin
          if (mH || mA[3:0] > 4'd9) fix = fix + 8'h06;
          if (mC || mA > 8'h99)     fix = fix + 8'h60;
          mA = mA + fix;
        end
      end
      default: ;
    endcase
  endtask

  task automatic checkAll(input string tag);
    check(tag, "acc",  accOut,               mA);
    check(tag, "c",    {7'd0, carryOut},     {7'd0, mC});
    check(tag, "hc",   {7'd0, halfCarryOut}, {7'd0, mH});
    check(tag, "cond", {7'd0, condOut},      {7'd0, mCond});
  endtask

  // Drive at a falling edge, sample at the next falling edge (one register stage)
  task automatic runOp(input logic [4:0] code, input logic [7:0] v);
    string tag;
    tag = reqOf(code);
    @(negedge clk);
    opValid = 1'b1; opCode = code; operand = v;
    @(negedge clk);
    opValid = 1'b0;
    modelStep(code, v);
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; opValid = 1'b0; opCode = 5'd0; operand = 8'h00;
    mA = 8'h00; mC = 1'b0; mH = 1'b0; mCond = 1'b0; mSub = 1'b0;
    // R2: reset state, with an operation presented during reset
    opValid = 1'b1; opCode = 5'd14; operand = 8'hFF;
    repeat (3) @(negedge clk);
    checkAll("R2");
    opValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R2");

    // R12: 0x99 + 0x01 then decimal correct gives 0x00
    runOp(5'd15, 8'h00);
    runOp(5'd5, 8'h99);
    runOp(5'd2, 8'h01);
    check("R4", "acc", accOut, 8'h9A);
    runOp(5'd16, 8'h00);
    check("R12", "acc", accOut, 8'h00);

    // R12: 0x38 + 0x49 -> 0x81 with HC set, corrected to 0x87
    runOp(5'd9, 8'h00);
    runOp(5'd5, 8'h38);
    runOp(5'd2, 8'h49);
    check("R4", "hc", {7'd0, halfCarryOut}, 8'h01);
    runOp(5'd16, 8'h00);
    check("R12", "acc", accOut, 8'h87);

    // R13: 10 - 01 in BCD: 0x0F corrected to 0x09
    runOp(5'd9, 8'h00);
    runOp(5'd5, 8'h10);
    runOp(5'd14, 8'h00);
    runOp(5'd3, 8'h01);
    check("R5", "acc", accOut, 8'h0F);
    check("R5", "c", {7'd0, carryOut}, 8'h01);
    runOp(5'd16, 8'h00);
    check("R13", "acc", accOut, 8'h09);

    // R5: borrow out -> C = 0; R13: 00 - 01 gives 99
    runOp(5'd9, 8'h00);
    runOp(5'd14, 8'h00);
    runOp(5'd3, 8'h01);
    check("R5", "c", {7'd0, carryOut}, 8'h00);
    runOp(5'd16, 8'h00);
    check("R13", "acc", accOut, 8'h99);

    // R7: unsigned compare, A unchanged
    runOp(5'd9, 8'h00);
    runOp(5'd5, 8'h80);
    runOp(5'd8, 8'h7F);
    check("R7", "cond", {7'd0, condOut}, 8'h01);
    runOp(5'd7, 8'h80);
    check("R7", "cond", {7'd0, condOut}, 8'h01);
    runOp(5'd4, 8'hFF);
    check("R7", "cond-hold", {7'd0, condOut}, 8'h01);
    runOp(5'd8, 8'h80);
    check("R7", "cond", {7'd0, condOut}, 8'h00);

    // R8 wrap, R9 rotate, R10 swap
    runOp(5'd9, 8'h00);
    runOp(5'd11, 8'h00);
    check("R8", "acc", accOut, 8'hFF);
    runOp(5'd10, 8'h00);
    check("R8", "acc", accOut, 8'h00);
    runOp(5'd5, 8'h01);
    runOp(5'd15, 8'h00);
    runOp(5'd12, 8'h00);
    check("R9", "c", {7'd0, carryOut}, 8'h01);
    runOp(5'd12, 8'h00);
    check("R9", "acc", accOut, 8'h80);
    runOp(5'd13, 8'h00);
    check("R10", "acc", accOut, 8'h08);

    // R1: valid low with a clear code, and unused codes, change nothing
    @(negedge clk);
    opValid = 1'b0; opCode = 5'd9; operand = 8'h00;
    @(negedge clk);
    checkAll("R1");
    for (int code = 17; code < 32; code++) runOp(5'(code), 8'hA5);

    // Random mix of every code
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] code;
      logic [7:0] v;
      code = 5'($urandom_range(0, 31));
      v    = 8'($urandom_range(0, 255));
      runOp(code, v);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule